// File: doc/BRIEF.md
# Eight-Source Interrupt Priority Chain

This block merges the interrupt requests of four serial channels onto one shared bus request line. Each channel raises two requests: "character received" and "transmitter ready". When the bus returns an acknowledge, the block either takes it for its highest-priority pending source or passes it on to the next device downstream. When it takes the acknowledge, it presents that source's interrupt vector until the bus reads it.

Every receive request outranks every transmit request. A receiver holds only one character, so it has the tighter deadline. A transmitter can wait indefinitely. The source is chosen when the acknowledge first rises, and that choice is frozen until the acknowledge is released. The block never clears a request: a request stays up until the channel itself withdraws it.

Top module: `irq_prio_chain`

## Requirements
- R1: `bus_req` is high one cycle after any of the eight request inputs is high, and low one cycle after all of them are low.
- R2: The order of priority is rx 0, rx 1, rx 2, rx 3, then tx 0, tx 1, tx 2, tx 3. Index 0 of each request vector is channel 0.
- R3: The vector for rx channel n is `vec_base + 8*n`. The vector for tx channel n is `vec_base + 8*n + 4`.
- R4: Suppose `ack_in` rises while no request is pending. Then `ack_out` goes high one cycle later and stays high while `ack_in` stays high, and `vec_valid` stays low.
- R5: `ack_out` and `vec_valid` are never high in the same cycle.
- R6: The choice between taking and passing the acknowledge is made in the cycle `ack_in` rises. Requests that change afterwards alter neither that choice nor `vec_out` until `ack_in` falls.
- R7: When `vec_rd` is high while `vec_valid` is high, `vec_valid` drops one cycle later. `ack_out` stays low until `ack_in` falls.
- R8: One cycle after `ack_in` is low, both `ack_out` and `vec_valid` are low.
- R9: Delivering a vector clears no request. A transmit request that loses to a receive request is granted on a later acknowledge.
- R10: After reset, `bus_req`, `ack_out` and `vec_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_req | input | NCH (4) | Receive-done requests, one per channel |
| tx_req | input | NCH (4) | Transmit-ready requests, one per channel |
| vec_base | input | VW (16) | Base of the vector block |
| ack_in | input | 1 | Acknowledge arriving from upstream |
| vec_rd | input | 1 | Bus has read the vector |
| bus_req | output | 1 | Shared interrupt request |
| ack_out | output | 1 | Acknowledge passed downstream |
| vec_valid | output | 1 | Vector is being driven |
| vec_out | output | VW (16) | Vector of the granted source |

## Verification
The bench uses the default build: NCH = 4 and VW = 16. With these values all eight stages of the chain exist, so every receive/transmit crossover in the priority order can be reached. Two different vector bases are used, so the offset arithmetic is checked against both even and carried sums. Requests are changed in the middle of an acknowledge, both while the block holds the acknowledge and while it is passing it on. This shows that the choice made on the rising edge is kept.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLAIM = 2'd1,
    ST_PASS  = 2'd2
  } chain_state_e;
endpackage

// File: rtl/irq_prio_stage.sv
// One link of the acknowledge chain: take the token if requesting, else forward it.
module irq_prio_stage (
  input  logic req,
  input  logic grant_in,
  output logic take,
  output logic grant_out
);
  always_comb begin
    take      = req & grant_in;
    grant_out = grant_in & ~req;
  end
endmodule

// File: rtl/irq_vec_gen.sv
// Maps the one-hot winning stage to its vector address.
module irq_vec_gen #(
  parameter int NCH = 4,
  parameter int VW  = 16
) (
  input  logic [2*NCH-1:0] take,
  input  logic [VW-1:0]    vec_base,
  output logic [VW-1:0]    vec
);
  localparam int NSRC = 2 * NCH;
  logic [VW-1:0] offset;

  always_comb begin
    offset = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (take[k]) begin
        if (k < NCH) offset = offset | VW'(k * 8);
        else         offset = offset | VW'((k - NCH) * 8 + 4);
      end
    end
    vec = vec_base + offset;
  end
endmodule

// File: rtl/irq_prio_chain.sv
module irq_prio_chain #(
  parameter int NCH = 4,
  parameter int VW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] rx_req,
  input  logic [NCH-1:0] tx_req,
  input  logic [VW-1:0]  vec_base,
  input  logic           ack_in,
  input  logic           vec_rd,
  output logic           bus_req,
  output logic           ack_out,
  output logic           vec_valid,
  output logic [VW-1:0]  vec_out
);
  import irq_chain_pkg::*;

  localparam int NSRC = 2 * NCH;

  // Stage order = priority order: receives first, then transmits.
  logic [NSRC-1:0] src_req;
  logic [NSRC:0]   grant;
  logic [NSRC-1:0] take;
  logic [VW-1:0]   vec_next;

  assign src_req  = {tx_req, rx_req};
  assign grant[0] = 1'b1;

  for (genvar k = 0; k < NSRC; k++) begin : g_stage
    irq_prio_stage u_stage (
      .req       (src_req[k]),
      .grant_in  (grant[k]),
      .take      (take[k]),
      .grant_out (grant[k+1])
    );
  end

  irq_vec_gen #(.NCH(NCH), .VW(VW)) u_vec (
    .take     (take),
    .vec_base (vec_base),
    .vec      (vec_next)
  );

  chain_state_e state;
  logic         ack_d;
  logic         ack_rise;

  assign ack_rise = ack_in & ~ack_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_d     <= 1'b0;
      bus_req   <= 1'b0;
      ack_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      ack_d   <= ack_in;
      bus_req <= |src_req;
      case (state)
        ST_IDLE: begin
          ack_out   <= 1'b0;
          vec_valid <= 1'b0;
          if (ack_rise) begin
            if (~grant[NSRC]) begin
              state     <= ST_CLAIM;
              vec_valid <= 1'b1;
              vec_out   <= vec_next;
            end else begin
              state   <= ST_PASS;
              ack_out <= 1'b1;
            end
          end
        end
        ST_CLAIM: begin
          ack_out <= 1'b0;
          if (!ack_in) begin
            state     <= ST_IDLE;
            vec_valid <= 1'b0;
          end else if (vec_rd) begin
            vec_valid <= 1'b0;
          end
        end
        ST_PASS: begin
          vec_valid <= 1'b0;
          if (!ack_in) begin
            state   <= ST_IDLE;
            ack_out <= 1'b0;
          end
        end
        default: begin
          state     <= ST_IDLE;
          ack_out   <= 1'b0;
          vec_valid <= 1'b0;
        end
      endcase
    end
  end

  // Assertions
  AST_BUSREQ_SET: assert property (@(posedge clk) disable iff (rst)
    (|{tx_req, rx_req}) |=> bus_req); // R1
  AST_BUSREQ_CLR: assert property (@(posedge clk) disable iff (rst)
    !(|{tx_req, rx_req}) |=> !bus_req); // R1
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ack_out && vec_valid)); // R5
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && $past(vec_valid)) |-> $stable(vec_out)); // R6
  AST_RD_DROP: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_rd) |=> !vec_valid); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !ack_in |=> (!ack_out && !vec_valid)); // R8
  AST_PASS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ack_in && !ack_d && !(|{tx_req, rx_req})) |=> ack_out); // R4
endmodule

// File: tb/irq_prio_chain_test.sv
module irq_prio_chain_test;
  localparam int NCH = 4;
  localparam int VW  = 16;

  logic           clk = 1'b0;
  logic           rst;
  logic [NCH-1:0] rx_req;
  logic [NCH-1:0] tx_req;
  logic [VW-1:0]  vec_base;
  logic           ack_in;
  logic           vec_rd;
  logic           bus_req;
  logic           ack_out;
  logic           vec_valid;
  logic [VW-1:0]  vec_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_prio_chain #(.NCH(NCH), .VW(VW)) uut (
    .clk(clk), .rst(rst), .rx_req(rx_req), .tx_req(tx_req),
    .vec_base(vec_base), .ack_in(ack_in), .vec_rd(vec_rd),
    .bus_req(bus_req), .ack_out(ack_out), .vec_valid(vec_valid),
    .vec_out(vec_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected vector from the priority rules.
  function automatic logic [VW-1:0] model_vec(logic [NCH-1:0] rx, logic [NCH-1:0] tx,
                                               logic [VW-1:0] base);
    for (int n = 0; n < NCH; n++)
      if (rx[n]) return base + VW'(8 * n);
    for (int n = 0; n < NCH; n++)
      if (tx[n]) return base + VW'(8 * n + 4);
    return '0;
  endfunction

  task automatic test_reset();
    rst = 1'b1; rx_req = '0; tx_req = '0; vec_base = 16'h0140;
    ack_in = 1'b0; vec_rd = 1'b0;
    tick(); tick();
    rst = 1'b0;
    tick();
    check("R10 bus_req", bus_req, 0);
    check("R10 ack_out", ack_out, 0);
    check("R10 vec_valid", vec_valid, 0);
  endtask

  task automatic test_bus_req();
    rx_req = 4'b0100; tick();
    check("R1 set rx", bus_req, 1);
    rx_req = '0; tx_req = 4'b1000; tick();
    check("R1 set tx", bus_req, 1);
    tx_req = '0; tick();
    check("R1 clear", bus_req, 0);
  endtask

  task automatic test_claim(logic [NCH-1:0] rx, logic [NCH-1:0] tx, logic [VW-1:0] base);
    logic [VW-1:0] exp;
    exp = model_vec(rx, tx, base);
    rx_req = rx; tx_req = tx; vec_base = base;
    tick();
    ack_in = 1'b1; tick();
    check("R2 R3 vec_valid", vec_valid, 1);
    check("R2 R3 vec_out", vec_out, exp);
    check("R5 ack_out low on claim", ack_out, 0);
    vec_rd = 1'b1; tick();
    vec_rd = 1'b0;
    check("R7 vec_valid drops", vec_valid, 0);
    check("R7 ack_out held low", ack_out, 0);
    tick();
    check("R7 ack_out still low", ack_out, 0);
    ack_in = 1'b0; tick();
    check("R8 ack_out", ack_out, 0);
    check("R8 vec_valid", vec_valid, 0);
    rx_req = '0; tx_req = '0;
  endtask

  task automatic test_pass();
    rx_req = '0; tx_req = '0; tick();
    ack_in = 1'b1; tick();
    check("R4 ack_out", ack_out, 1);
    check("R4 vec_valid", vec_valid, 0);
    rx_req = 4'b0001; tick();
    check("R6 pass kept", ack_out, 1);
    check("R6 no claim mid pass", vec_valid, 0);
    ack_in = 1'b0; tick();
    check("R8 pass released", ack_out, 0);
    rx_req = '0;
  endtask

  task automatic test_latch();
    vec_base = 16'h0200; rx_req = '0; tx_req = 4'b0100; tick();
    ack_in = 1'b1; tick();
    check("R6 vec tx2", vec_out, 16'h0214);
    rx_req = 4'b0001; tick();
    check("R6 vec held", vec_out, 16'h0214);
    check("R6 still claimed", vec_valid, 1);
    ack_in = 1'b0; tick();
    rx_req = '0; tx_req = '0;
  endtask

  task automatic test_hold();
    vec_base = 16'h0300; rx_req = 4'b0001; tx_req = 4'b0010; tick();
    ack_in = 1'b1; tick();
    check("R9 rx0 first", vec_out, 16'h0300);
    vec_rd = 1'b1; tick(); vec_rd = 1'b0;
    ack_in = 1'b0; tick();
    check("R9 bus_req held", bus_req, 1);
    rx_req = '0; tick();
    check("R9 tx still requesting", bus_req, 1);
    ack_in = 1'b1; tick();
    check("R9 tx1 granted later", vec_out, 16'h030C);
    check("R9 vec_valid", vec_valid, 1);
    ack_in = 1'b0; tx_req = '0; tick(); tick();
    check("R1 all clear", bus_req, 0);
  endtask

  initial begin
    test_reset();
    test_bus_req();
    test_claim(4'b1000, 4'b0001, 16'h0140);
    test_claim(4'b0000, 4'b1010, 16'h0140);
    test_claim(4'b1111, 4'b1111, 16'h0140);
    test_claim(4'b0000, 4'b1000, 16'h00F8);
    test_claim(4'b0010, 4'b0001, 16'h00F8);
    test_pass();
    test_latch();
    test_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule